// File: doc/BRIEF.md
# Hub Port Power and Indicator Controller

This block sits beside a four-port hub's device logic and owns the port power switches and the status lamps. Firmware and the hub state machine feed it per-port enable requests, per-port transfer-activity flags, a hub-wide suspend flag and a hub-wide reset flag. A strap selects whether the four power switches act as one group or separately. Each downstream port has an active-low over-current sense line. The block filters that line and turns a confirmed fault into a sticky per-port flag. The flag shuts the affected power switch off, and in group mode it shuts off all four.

All outputs are active low and come straight from flip-flops. That covers the four power enables, one lamp for the upstream (root) side and one lamp per downstream port. Firmware reads the fault flags and clears each one with a one-cycle pulse. Power comes back only when the port enable is then dropped and raised again.

Top module: `hub_pwr_led_ctrl`

## Requirements
- R1: While `rst_n` is low, `pwr_en_n` is 4'b1111, `root_led_n` is 1, `port_led_n` is 4'b1111 and `oc_flag` is 4'b0000.
- R2: With `gang_mode`=0 and no fault lockout, `pwr_en_n[i]` is 0 (power on) exactly when `port_en[i]` was 1 at the previous clock edge and `hub_reset` was 0.
- R3: With `gang_mode`=1, all four bits of `pwr_en_n` are equal. They are 0 when at least one `port_en` bit was 1 and no port is locked out.
- R4: `oc_sense_n[i]`=0 means over-current. It passes through two synchronising flops. A low run of at least FILT_CYC consecutive cycles sets `oc_flag[i]` at the (FILT_CYC+3)th rising edge after the line falls. A run of FILT_CYC-1 cycles sets nothing.
- R5: The edge that sets `oc_flag[i]` also drives `pwr_en_n[i]` high. In group mode it drives all four bits high.
- R6: `oc_flag[i]` stays set until a `flag_clr[i]` pulse arrives while no confirmed fault is present. A confirmed fault wins over a clear in the same cycle.
- R7: After a fault, power for a port stays off until its flag is clear and its enable has then been seen low and high again. In group mode, all enables must be seen low.
- R8: One edge after `hub_reset` is 1, every power enable and every lamp output is 1.
- R9: `root_led_n` is 0 exactly when, at the previous edge, `hub_reset`, `hub_suspend` and `root_busy` were all 0.
- R10: `port_led_n[i]` is 0 exactly when port i's power is on after the same edge and `hub_suspend` and `port_busy[i]` were 0.
- R11: Outputs change only at a rising clock edge. An input change between edges leaves every output unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gang_mode | input | 1 | 1: the four power switches act as one group; 0: per port |
| hub_reset | input | 1 | Hub is in reset |
| hub_suspend | input | 1 | Hub is suspended |
| root_busy | input | 1 | Transfer in progress on the upstream side |
| port_en | input | 4 | Per-port power request |
| port_busy | input | 4 | Per-port transfer in progress |
| oc_sense_n | input | 4 | Per-port over-current sense, 0 = fault |
| flag_clr | input | 4 | Per-port fault flag clear pulse |
| pwr_en_n | output | 4 | Per-port power enable, 0 = on |
| root_led_n | output | 1 | Upstream lamp, 0 = lit |
| port_led_n | output | 4 | Per-port lamp, 0 = lit |
| oc_flag | output | 4 | Sticky per-port fault flag |

## Verification
A filter counter that is off by one shows up at the fault flag one edge early or late, so the bench samples around the exact (FILT_CYC+3)th edge. A lockout bit that stays stuck or clears too early shows up one edge after the enable is toggled. Power is then either restored too early or never restored. A wrong group-mode decision splits `pwr_en_n` into unequal bits on the first edge after the strap or an enable changes. A cycle-accurate bench model flags every such divergence on the edge where it first appears.

// File: rtl/hub_pwr_pkg.sv
package hub_pwr_pkg;

    localparam int unsigned HUB_DS_PORTS = 4;

    typedef logic [HUB_DS_PORTS-1:0] port_vec_t;

    typedef struct packed {
        port_vec_t flag;
        port_vec_t lock;
        port_vec_t pwr_n;
        logic      root_led_n;
        port_vec_t led_n;
    } hub_ctl_state_t;

endpackage

// File: rtl/hub_oc_filter.sv
module hub_oc_filter #(
    parameter int unsigned FILT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_n_i,
    output logic fault_o
);

    localparam int unsigned CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(FILT_CYC);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
    } filt_state_t;

    filt_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.sync = {state_q.sync[0], oc_n_i};
        if (!state_q.sync[1]) begin
            state_d.cnt = (state_q.cnt == CNT_MAX) ? CNT_MAX : state_q.cnt + 1'b1;
        end else begin
            state_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.sync <= 2'b11;
            state_q.cnt  <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fault_o = (state_q.cnt == CNT_MAX);

    // R4: a fault can only appear after the synchronised line was low
    assert_fault_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> !$past(state_q.sync[1]));

    // R4: a high synchronised level removes the fault on the next edge
    assert_fault_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.sync[1] |=> !fault_o);

endmodule

// File: rtl/hub_port_ctl.sv
module hub_port_ctl
    import hub_pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      gang_i,
    input  logic      hub_reset_i,
    input  logic      hub_suspend_i,
    input  logic      root_busy_i,
    input  port_vec_t port_en_i,
    input  port_vec_t port_busy_i,
    input  port_vec_t fault_i,
    input  port_vec_t flag_clr_i,
    output port_vec_t pwr_en_n_o,
    output logic      root_led_n_o,
    output port_vec_t port_led_n_o,
    output port_vec_t oc_flag_o
);

    hub_ctl_state_t state_d, state_q;
    port_vec_t      on_v;
    logic           gang_on;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < HUB_DS_PORTS; i++) begin
            state_d.flag[i] = fault_i[i] | (state_q.flag[i] & ~flag_clr_i[i]);
            state_d.lock[i] = state_d.flag[i] |
                              (state_q.lock[i] & (gang_i ? (|port_en_i) : port_en_i[i]));
        end
        gang_on = (|port_en_i) & ~(|state_d.lock);
        for (int i = 0; i < HUB_DS_PORTS; i++) begin
            on_v[i]          = gang_i ? gang_on : (port_en_i[i] & ~state_d.lock[i]);
            state_d.pwr_n[i] = hub_reset_i | ~on_v[i];
            state_d.led_n[i] = hub_reset_i | hub_suspend_i | port_busy_i[i] | ~on_v[i];
        end
        state_d.root_led_n = hub_reset_i | hub_suspend_i | root_busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.flag       <= '0;
            state_q.lock       <= '0;
            state_q.pwr_n      <= '1;
            state_q.root_led_n <= 1'b1;
            state_q.led_n      <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign pwr_en_n_o   = state_q.pwr_n;
    assign root_led_n_o = state_q.root_led_n;
    assign port_led_n_o = state_q.led_n;
    assign oc_flag_o    = state_q.flag;

    assert_reset_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hub_reset_i |=> ((&pwr_en_n_o) && root_led_n_o && (&port_led_n_o)));

    assert_gang_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gang_i) |-> (pwr_en_n_o == '0 || pwr_en_n_o == '1));

    assert_root_led_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hub_suspend_i || root_busy_i) |-> root_led_n_o);

    for (genvar g = 0; g < HUB_DS_PORTS; g++) begin : g_chk
        assert_fault_kills_power_R5: assert property (@(posedge clk) disable iff (!rst_n)
            fault_i[g] |=> (pwr_en_n_o[g] && oc_flag_o[g]));

        assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(oc_flag_o[g]) |-> ($past(flag_clr_i[g]) && !$past(fault_i[g])));

        assert_led_needs_power_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !port_led_n_o[g] |-> !pwr_en_n_o[g]);
    end

endmodule

// File: rtl/hub_pwr_led_ctrl.sv
module hub_pwr_led_ctrl
    import hub_pwr_pkg::*;
#(
    parameter int unsigned FILT_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gang_mode,
    input  logic       hub_reset,
    input  logic       hub_suspend,
    input  logic       root_busy,
    input  logic [3:0] port_en,
    input  logic [3:0] port_busy,
    input  logic [3:0] oc_sense_n,
    input  logic [3:0] flag_clr,
    output logic [3:0] pwr_en_n,
    output logic       root_led_n,
    output logic [3:0] port_led_n,
    output logic [3:0] oc_flag
);

    port_vec_t fault_v;

    for (genvar g = 0; g < HUB_DS_PORTS; g++) begin : g_filt
        hub_oc_filter #(
            .FILT_CYC (FILT_CYC)
        ) filt_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .oc_n_i  (oc_sense_n[g]),
            .fault_o (fault_v[g])
        );
    end

    hub_port_ctl ctl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .gang_i        (gang_mode),
        .hub_reset_i   (hub_reset),
        .hub_suspend_i (hub_suspend),
        .root_busy_i   (root_busy),
        .port_en_i     (port_en),
        .port_busy_i   (port_busy),
        .fault_i       (fault_v),
        .flag_clr_i    (flag_clr),
        .pwr_en_n_o    (pwr_en_n),
        .root_led_n_o  (root_led_n),
        .port_led_n_o  (port_led_n),
        .oc_flag_o     (oc_flag)
    );

endmodule

// File: tb/hub_pwr_led_ctrl_tb_top.sv
module hub_pwr_led_ctrl_tb_top;

    localparam int FILT = 8;

    logic       clk = 1'b0;
    logic       rst_n, gang_mode, hub_reset, hub_suspend, root_busy;
    logic [3:0] port_en, port_busy, oc_sense_n, flag_clr;
    logic [3:0] pwr_en_n, port_led_n, oc_flag;
    logic       root_led_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [3:0] m_s1, m_s2, m_flag, m_lock, m_pwr, m_pled;
    logic       m_rled;
    int         m_cnt [4];

    always #2 clk = ~clk;

    hub_pwr_led_ctrl #(.FILT_CYC(FILT)) dut_i (
        .clk(clk), .rst_n(rst_n), .gang_mode(gang_mode), .hub_reset(hub_reset),
        .hub_suspend(hub_suspend), .root_busy(root_busy), .port_en(port_en),
        .port_busy(port_busy), .oc_sense_n(oc_sense_n), .flag_clr(flag_clr),
        .pwr_en_n(pwr_en_n), .root_led_n(root_led_n), .port_led_n(port_led_n),
        .oc_flag(oc_flag)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] gang_or_ind_on(input logic [3:0] lk);
        logic [3:0] on;
        logic       gon = (|port_en) & ~(|lk);
        for (int i = 0; i < 4; i++) on[i] = gang_mode ? gon : (port_en[i] & ~lk[i]);
        return on;
    endfunction

    task automatic model_step();
        logic [3:0] fault, nflag, nlock, on;
        if (!rst_n) begin
            m_s1 = 4'hF; m_s2 = 4'hF; m_flag = '0; m_lock = '0;
            m_pwr = 4'hF; m_pled = 4'hF; m_rled = 1'b1;
            for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                fault[i] = (m_cnt[i] == FILT);
                if (!m_s2[i]) m_cnt[i] = (m_cnt[i] == FILT) ? FILT : m_cnt[i] + 1;
                else m_cnt[i] = 0;
            end
            m_s2 = m_s1;
            m_s1 = oc_sense_n;
            nflag = fault | (m_flag & ~flag_clr);
            for (int i = 0; i < 4; i++)
                nlock[i] = nflag[i] | (m_lock[i] & (gang_mode ? (|port_en) : port_en[i]));
            on = gang_or_ind_on(nlock);
            m_flag = nflag;
            m_lock = nlock;
            m_pwr  = {4{hub_reset}} | ~on;
            m_pled = {4{hub_reset | hub_suspend}} | port_busy | ~on;
            m_rled = hub_reset | hub_suspend | root_busy;
        end
    endtask

    task automatic compare();
        chk(pwr_en_n == m_pwr, gang_mode ? "R3" : "R2", "pwr_en_n", 32'(pwr_en_n), 32'(m_pwr));
        chk(oc_flag == m_flag, "R4", "oc_flag", 32'(oc_flag), 32'(m_flag));
        chk(port_led_n == m_pled, "R10", "port_led_n", 32'(port_led_n), 32'(m_pled));
        chk(root_led_n == m_rled, "R9", "root_led_n", 32'(root_led_n), 32'(m_rled));
    endtask

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; gang_mode = 1'b0; hub_reset = 1'b0; hub_suspend = 1'b0;
        root_busy = 1'b0; port_en = '0; port_busy = '0; oc_sense_n = 4'hF; flag_clr = '0;
        tick(3);
        chk(pwr_en_n == 4'hF && port_led_n == 4'hF && root_led_n && oc_flag == 4'h0,
            "R1", "reset state", {pwr_en_n, port_led_n, oc_flag, 3'b0, root_led_n}, 32'hFF01);
        rst_n = 1'b1;
        tick(1);

        // R11: no change between edges
        port_en = 4'b0010;
        #1;
        chk(pwr_en_n == 4'hF, "R11", "pwr before edge", 32'(pwr_en_n), 32'hF);
        @(negedge clk);
        tick(1);
        chk(pwr_en_n == 4'b1101, "R2", "single enable", 32'(pwr_en_n), 32'hD);
        chk(port_led_n == 4'b1101, "R10", "lamp follows power", 32'(port_led_n), 32'hD);
        port_en = 4'b0101; tick(1);
        chk(pwr_en_n == 4'b1010, "R2", "two enables", 32'(pwr_en_n), 32'hA);

        root_busy = 1'b1; tick(1);
        chk(root_led_n == 1'b1, "R9", "root busy", 32'(root_led_n), 1);
        root_busy = 1'b0; hub_suspend = 1'b1; tick(1);
        chk(root_led_n == 1'b1 && port_led_n == 4'hF, "R10", "suspend dark",
            {port_led_n, 3'b0, root_led_n}, 32'hF1);
        hub_suspend = 1'b0; tick(1);
        chk(root_led_n == 1'b0, "R9", "root idle lit", 32'(root_led_n), 0);

        // R4 short run ignored
        port_en = 4'hF; tick(1);
        oc_sense_n[0] = 1'b0; tick(FILT - 1);
        oc_sense_n[0] = 1'b1; tick(6);
        chk(oc_flag == 4'h0 && pwr_en_n == 4'h0, "R4", "short run ignored",
            {oc_flag, pwr_en_n}, 32'h00);
        // R4 exact edge
        oc_sense_n[0] = 1'b0; tick(FILT + 2);
        chk(oc_flag == 4'h0, "R4", "flag not yet", 32'(oc_flag), 0);
        tick(1);
        chk(oc_flag == 4'h1, "R4", "flag on time", 32'(oc_flag), 1);
        chk(pwr_en_n == 4'b0001 && port_led_n[0], "R5", "faulted port off", 32'(pwr_en_n), 1);
        // R6 fault wins over clear
        flag_clr = 4'b0001; tick(1); flag_clr = '0;
        chk(oc_flag == 4'h1, "R6", "clear during fault", 32'(oc_flag), 1);
        oc_sense_n[0] = 1'b1; tick(4);
        chk(oc_flag == 4'h1, "R6", "sticky after release", 32'(oc_flag), 1);
        flag_clr = 4'b0001; tick(1); flag_clr = '0;
        chk(oc_flag == 4'h0, "R6", "cleared", 32'(oc_flag), 0);
        chk(pwr_en_n[0] == 1'b1, "R7", "still locked", 32'(pwr_en_n[0]), 1);
        port_en[0] = 1'b0; tick(1); port_en[0] = 1'b1; tick(1);
        chk(pwr_en_n == 4'h0, "R7", "restored", 32'(pwr_en_n), 0);

        // group mode
        gang_mode = 1'b1; port_en = 4'b0001; tick(1);
        chk(pwr_en_n == 4'h0, "R3", "group on", 32'(pwr_en_n), 0);
        port_en = 4'b0000; tick(1);
        chk(pwr_en_n == 4'hF, "R3", "group off", 32'(pwr_en_n), 32'hF);
        port_en = 4'b1000; tick(1);
        oc_sense_n[2] = 1'b0; tick(FILT + 3);
        chk(pwr_en_n == 4'hF && oc_flag == 4'b0100, "R5", "group fault",
            {oc_flag, pwr_en_n}, 32'h4F);
        oc_sense_n[2] = 1'b1; tick(4);
        flag_clr = 4'b0100; tick(1); flag_clr = '0; tick(1);
        chk(pwr_en_n == 4'hF, "R7", "group locked", 32'(pwr_en_n), 32'hF);
        port_en = '0; tick(1); port_en = 4'b1000; tick(1);
        chk(pwr_en_n == 4'h0, "R7", "group restored", 32'(pwr_en_n), 0);

        hub_reset = 1'b1; tick(1);
        chk(pwr_en_n == 4'hF && port_led_n == 4'hF && root_led_n, "R8", "hub reset",
            {pwr_en_n, port_led_n, 3'b0, root_led_n}, 32'hFF1);
        hub_reset = 1'b0; gang_mode = 1'b0; port_en = 4'hF; tick(1);

        // random phase
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < 4; i++) begin
                if ($urandom_range(63) == 0) port_en[i] = ~port_en[i];
                if ($urandom_range(39) == 0) oc_sense_n[i] = ~oc_sense_n[i];
                flag_clr[i] = ($urandom_range(49) == 0);
                port_busy[i] = ($urandom_range(3) == 0);
            end
            root_busy = ($urandom_range(3) == 0);
            if ($urandom_range(199) == 0) hub_suspend = ~hub_suspend;
            hub_reset = ($urandom_range(299) == 0);
            if ($urandom_range(499) == 0) gang_mode = ~gang_mode;
            tick(1);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule